// File: doc/BRIEF.md
# SpaceWire Receive Packet Classifier

This block sits behind a SpaceWire receiver and looks at every arriving packet one character at a time. Each character is either a data byte or an end marker. The end marker is either a normal end of packet or an error end. From the leading bytes of a packet the block decides where the whole packet goes. It can throw the packet away, pass it to a hardware remote-memory-access command engine, or pass it to the DMA channel that stores packets for software. Every character of an accepted packet leaves on the chosen port in arrival order. This includes the address byte and the end marker.

The first byte is compared with the configured node address. A promiscuous setting accepts any address. When the remote-access target is both present and enabled, the second byte is read as a protocol identifier, and the third byte holds the instruction. Only a command (instruction bit 6 set) under protocol 0x01 reaches the hardware engine. Replies, extended-identifier packets (second byte 0x00) and all other protocols go to DMA. When the target is off, the decision is taken on the address byte alone, so no protocol byte is needed.

Until the decision is made, the leading characters are held in a small queue. The decisions of packets waiting in that queue sit in a second queue, so packets that arrive back to back keep their own routes.

Top module: `spw_rx_classifier`

## Requirements
- R1: After reset, both output ports are idle, the destination tag is 2'b00 and the mismatch pulse is low.
- R2: With promiscuous mode off, a packet whose first byte differs from the node address produces no character on either port, up to and including its end marker. One cycle after the address byte is taken, `addr_mismatch` is high for exactly one cycle.
- R3: With promiscuous mode on, a packet with a non-matching address is accepted and routed by the rules that follow.
- R4: When `rmap_present` and `rmap_enable` are both high, a packet whose second byte is 0x01 and whose third byte has bit 6 set leaves entirely on the RMAP port.
- R5: A packet whose second byte is 0x01 and whose third byte has bit 6 clear (a reply) leaves on the DMA port, even when the target is enabled.
- R6: When the target is absent or disabled, every accepted packet leaves on the DMA port, including commands under protocol 0x01.
- R7: A packet whose second byte is 0x00 leaves on the DMA port. This holds when the bytes that follow look like a command, and it holds for the all-zero reserved extended identifier.
- R8: A packet with any other protocol byte leaves on the DMA port.
- R9: A packet that ends before its route is known leaves on the DMA port with its end-marker kind kept. This covers a packet that is only an end marker and a packet that ends after its address or protocol byte.
- R10: Every accepted character leaves once, in order, on a single port. An end marker appears with `*_end` high and data 0x00, and `*_err` is high only for an error end. Back-to-back packets each keep their own route.
- R11: While a character is valid, `out_dest` is 2'b01 for the DMA port and 2'b10 for the RMAP port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Character present this cycle |
| in_data | input | 8 | Data byte (ignored for end markers) |
| in_end | input | 1 | Character is an end marker |
| in_err | input | 1 | End marker is an error end (valid with in_end) |
| node_addr | input | 8 | Node address to match against the first byte |
| promisc_en | input | 1 | Accept packets of any address |
| rmap_present | input | 1 | Remote-access target is built in |
| rmap_enable | input | 1 | Remote-access target is switched on |
| dma_valid | output | 1 | Character valid on the DMA port |
| dma_data | output | 8 | DMA port byte |
| dma_end | output | 1 | DMA port character is an end marker |
| dma_err | output | 1 | DMA port end marker is an error end |
| rmap_valid | output | 1 | Character valid on the RMAP port |
| rmap_data | output | 8 | RMAP port byte |
| rmap_end | output | 1 | RMAP port character is an end marker |
| rmap_err | output | 1 | RMAP port end marker is an error end |
| out_dest | output | 2 | Destination tag of the current output character |
| addr_mismatch | output | 1 | One-cycle pulse when a packet is dropped on its address |

## Verification
A wrong classification state shows up quickly. Within a few cycles of a packet's third byte, the packet appears on the wrong port or never appears, and the stray bytes show up on the other port's captured stream. A decision queue that falls out of step with the data queue shows up only on back-to-back packets. There, the second packet inherits the first packet's route, or stalls until its own end marker. The burst scenario exposes this by mixing a command, a dropped packet and a DMA packet with no idle cycles between them. A drop state that fails to clear leaves the next good packet missing entirely, and the following test catches this.

// File: rtl/spw_rx_classifier.sv
module spw_rx_classifier #(
  parameter int          FIFO_DEPTH = 4,
  parameter int          DEC_DEPTH  = 4,
  parameter logic [7:0]  RMAP_PROTO = 8'h01,
  parameter int          CMD_BIT    = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_end,
  input  logic       in_err,
  input  logic [7:0] node_addr,
  input  logic       promisc_en,
  input  logic       rmap_present,
  input  logic       rmap_enable,
  output logic       dma_valid,
  output logic [7:0] dma_data,
  output logic       dma_end,
  output logic       dma_err,
  output logic       rmap_valid,
  output logic [7:0] rmap_data,
  output logic       rmap_end,
  output logic       rmap_err,
  output logic [1:0] out_dest,
  output logic       addr_mismatch
);
  // depths are powers of two so pointers wrap naturally
  localparam int FAW = $clog2(FIFO_DEPTH);
  localparam int DAW = $clog2(DEC_DEPTH);
  localparam logic [FAW:0] F_FULL = FIFO_DEPTH[FAW:0];
  localparam logic [DAW:0] D_FULL = DEC_DEPTH[DAW:0];

  typedef enum logic [2:0] {S_ADDR, S_PROTO, S_INSTR, S_FWD, S_DROP} cls_t;

  cls_t st, st_nx;
  logic push, dec_push, dec_rmap, mism;
  logic tgt_on, addr_ok;

  assign tgt_on  = rmap_present & rmap_enable;
  assign addr_ok = promisc_en | (in_data == node_addr);

  always_comb begin
    st_nx    = st;
    push     = 1'b0;
    dec_push = 1'b0;
    dec_rmap = 1'b0;
    mism     = 1'b0;
    if (in_valid) begin
      case (st)
        S_ADDR: begin
          if (in_end) begin
            push     = 1'b1;
            dec_push = 1'b1;
          end else if (!addr_ok) begin
            mism  = 1'b1;
            st_nx = S_DROP;
          end else begin
            push = 1'b1;
            if (tgt_on) st_nx = S_PROTO;
            else begin
              dec_push = 1'b1;
              st_nx    = S_FWD;
            end
          end
        end
        S_PROTO: begin
          push = 1'b1;
          if (in_end) begin
            dec_push = 1'b1;
            st_nx    = S_ADDR;
          end else if (in_data == RMAP_PROTO) begin
            st_nx = S_INSTR;
          end else begin
            dec_push = 1'b1;
            st_nx    = S_FWD;
          end
        end
        S_INSTR: begin
          push     = 1'b1;
          dec_push = 1'b1;
          if (in_end) st_nx = S_ADDR;
          else begin
            dec_rmap = in_data[CMD_BIT];
            st_nx    = S_FWD;
          end
        end
        S_FWD: begin
          push = 1'b1;
          if (in_end) st_nx = S_ADDR;
        end
        S_DROP: begin
          if (in_end) st_nx = S_ADDR;
        end
        default: st_nx = S_ADDR;
      endcase
    end
  end

  // character queue: {end, err, data}
  logic [9:0]     fmem [FIFO_DEPTH];
  logic [FAW-1:0] f_wr, f_rd;
  logic [FAW:0]   f_cnt;
  // route queue: 1 = RMAP port
  logic [DEC_DEPTH-1:0] dmem;
  logic [DAW-1:0] d_wr, d_rd;
  logic [DAW:0]   d_cnt;

  logic       pop, dec_pop;
  logic [9:0] head;

  assign head    = fmem[f_rd];
  assign pop     = (f_cnt != '0) && (d_cnt != '0);
  assign dec_pop = pop & head[9];

  always_ff @(posedge clk) begin
    if (push) fmem[f_wr] <= {in_end, in_end & in_err, in_end ? 8'h00 : in_data};
    if (dec_push) dmem[d_wr] <= dec_rmap;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_ADDR;
      f_wr  <= '0;
      f_rd  <= '0;
      f_cnt <= '0;
      d_wr  <= '0;
      d_rd  <= '0;
      d_cnt <= '0;
    end else begin
      st <= st_nx;
      if (push) f_wr <= f_wr + FAW'(1);
      if (pop)  f_rd <= f_rd + FAW'(1);
      f_cnt <= f_cnt + {{FAW{1'b0}}, push} - {{FAW{1'b0}}, pop};
      if (dec_push) d_wr <= d_wr + DAW'(1);
      if (dec_pop)  d_rd <= d_rd + DAW'(1);
      d_cnt <= d_cnt + {{DAW{1'b0}}, dec_push} - {{DAW{1'b0}}, dec_pop};
    end
  end

  logic       o_vld, o_rmap, o_end, o_err, o_mism;
  logic [7:0] o_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      o_vld  <= 1'b0;
      o_rmap <= 1'b0;
      o_end  <= 1'b0;
      o_err  <= 1'b0;
      o_data <= '0;
      o_mism <= 1'b0;
    end else begin
      o_vld  <= pop;
      o_mism <= mism;
      if (pop) begin
        o_rmap <= dmem[d_rd];
        o_end  <= head[9];
        o_err  <= head[8];
        o_data <= head[7:0];
      end
    end
  end

  assign dma_valid     = o_vld & ~o_rmap;
  assign rmap_valid    = o_vld & o_rmap;
  assign dma_data      = o_data;
  assign rmap_data     = o_data;
  assign dma_end       = o_end;
  assign rmap_end      = o_end;
  assign dma_err       = o_err;
  assign rmap_err      = o_err;
  assign out_dest      = !o_vld ? 2'b00 : (o_rmap ? 2'b10 : 2'b01);
  assign addr_mismatch = o_mism;

  // R2
  mismatch_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_mismatch |=> !addr_mismatch);

  // R4
  rmap_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rmap_valid |-> (rmap_present && rmap_enable));

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> ((f_cnt < F_FULL) || pop));

  // R10
  route_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_push |-> ((d_cnt < D_FULL) || dec_pop));

  // R2
  drop_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DROP) |-> !push);
endmodule

// File: tb/spw_rx_classifier_tb.sv
`timescale 1ns/1ps
module spw_rx_classifier_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       in_valid = 1'b0, in_end = 1'b0, in_err = 1'b0;
  logic [7:0] in_data = '0;
  logic [7:0] node_addr = 8'h42;
  logic       promisc_en = 1'b0, rmap_present = 1'b0, rmap_enable = 1'b0;
  logic       dma_valid, dma_end, dma_err, rmap_valid, rmap_end, rmap_err, addr_mismatch;
  logic [7:0] dma_data, rmap_data;
  logic [1:0] out_dest;

  spw_rx_classifier dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_end(in_end), .in_err(in_err), .node_addr(node_addr),
    .promisc_en(promisc_en), .rmap_present(rmap_present), .rmap_enable(rmap_enable),
    .dma_valid(dma_valid), .dma_data(dma_data), .dma_end(dma_end), .dma_err(dma_err),
    .rmap_valid(rmap_valid), .rmap_data(rmap_data), .rmap_end(rmap_end), .rmap_err(rmap_err),
    .out_dest(out_dest), .addr_mismatch(addr_mismatch));

  int checks = 0, errors = 0, mis_n = 0, tag_bad = 0;
  bit done = 0;
  logic [9:0] dq[$];
  logic [9:0] rq[$];
  logic [9:0] exp_d[$];
  logic [9:0] exp_r[$];
  logic [7:0] pkt [0:15];

  always @(negedge clk) if (rst_n) begin
    if (dma_valid) begin
      dq.push_back({dma_end, dma_err, dma_data});
      if (out_dest != 2'b01) tag_bad++;
    end
    if (rmap_valid) begin
      rq.push_back({rmap_end, rmap_err, rmap_data});
      if (out_dest != 2'b10) tag_bad++;
    end
    if (!dma_valid && !rmap_valid && out_dest != 2'b00) tag_bad++;
    if (addr_mismatch) mis_n++;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic send_char(input logic [7:0] d, input logic e, input logic er);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_end = e; in_err = er;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0; in_end = 1'b0; in_err = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_pkt(input int len, input logic err, input int dest);
    for (int i = 0; i < len; i++) begin
      send_char(pkt[i], 1'b0, 1'b0);
      if (dest == 1) exp_d.push_back({2'b00, pkt[i]});
      if (dest == 2) exp_r.push_back({2'b00, pkt[i]});
    end
    send_char(8'hEE, 1'b1, err);
    if (dest == 1) exp_d.push_back({1'b1, err, 8'h00});
    if (dest == 2) exp_r.push_back({1'b1, err, 8'h00});
  endtask

  task automatic clear_all();
    dq.delete(); rq.delete(); exp_d.delete(); exp_r.delete();
    mis_n = 0; tag_bad = 0;
  endtask

  task automatic compare(input string req, input int exp_mis);
    int bad_d, bad_r;
    bad_d = 0; bad_r = 0;
    chk(req, "dma count", dq.size(), exp_d.size());
    chk(req, "rmap count", rq.size(), exp_r.size());
    if (dq.size() == exp_d.size())
      foreach (dq[i]) if (dq[i] != exp_d[i]) bad_d++;
    if (rq.size() == exp_r.size())
      foreach (rq[i]) if (rq[i] != exp_r[i]) bad_r++;
    chk(req, "dma content mismatches", bad_d, 0);
    chk(req, "rmap content mismatches", bad_r, 0);
    chk(req, "mismatch pulses", mis_n, exp_mis);
    chk("R11", "dest tag errors", tag_bad, 0);
  endtask

  task automatic run_case(input string req, input int len, input logic err, input int dest);
    clear_all();
    send_pkt(len, err, dest);
    idle(12);
    compare(req, (dest == 0) ? 1 : 0);
  endtask

  task automatic set3(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
    pkt[0] = a; pkt[1] = b; pkt[2] = c;
    for (int i = 3; i < 16; i++) pkt[i] = 8'(8'h10 + i);
  endtask

  task automatic t_reset();
    chk("R1", "dma_valid", int'(dma_valid), 0);
    chk("R1", "rmap_valid", int'(rmap_valid), 0);
    chk("R1", "out_dest", int'(out_dest), 0);
    chk("R1", "addr_mismatch", int'(addr_mismatch), 0);
  endtask

  task automatic t_target_off();
    rmap_present = 1'b0; rmap_enable = 1'b1;
    set3(8'h42, 8'h01, 8'h4C); run_case("R6 absent", 6, 1'b0, 1);
    rmap_present = 1'b1; rmap_enable = 1'b0;
    set3(8'h42, 8'h01, 8'h4C); run_case("R6 disabled", 6, 1'b0, 1);
    set3(8'h42, 8'h99, 8'h00); run_case("R6 no proto", 2, 1'b0, 1);
  endtask

  task automatic t_command();
    rmap_present = 1'b1; rmap_enable = 1'b1;
    set3(8'h42, 8'h01, 8'h4C); run_case("R4 command", 8, 1'b0, 2);
    set3(8'h42, 8'h01, 8'h7F); run_case("R10 command error end", 5, 1'b1, 2);
  endtask

  task automatic t_reply();
    set3(8'h42, 8'h01, 8'h0C); run_case("R5 reply", 7, 1'b0, 1);
  endtask

  task automatic t_drop();
    set3(8'h43, 8'h01, 8'h4C); run_case("R2 drop", 6, 1'b0, 0);
    set3(8'h42, 8'h01, 8'h4C); run_case("R2 next after drop", 4, 1'b0, 2);
  endtask

  task automatic t_promisc();
    promisc_en = 1'b1;
    set3(8'h77, 8'h05, 8'h4C); run_case("R3 promiscuous", 5, 1'b0, 1);
    promisc_en = 1'b0;
  endtask

  task automatic t_ext();
    set3(8'h42, 8'h00, 8'h01); pkt[3] = 8'h4C; run_case("R7 extended", 6, 1'b0, 1);
    set3(8'h42, 8'h00, 8'h00); pkt[3] = 8'h00; pkt[4] = 8'h00;
    run_case("R7 reserved", 5, 1'b0, 1);
  endtask

  task automatic t_other();
    set3(8'h42, 8'h22, 8'h4C); run_case("R8 other proto", 5, 1'b0, 1);
  endtask

  task automatic t_short();
    set3(8'h42, 8'h01, 8'h4C);
    run_case("R9 empty", 0, 1'b0, 1);
    run_case("R9 addr only", 1, 1'b1, 1);
    run_case("R9 addr+proto", 2, 1'b1, 1);
    run_case("R9 addr+proto ok", 2, 1'b0, 1);
  endtask

  task automatic t_burst();
    clear_all();
    set3(8'h42, 8'h01, 8'h48); send_pkt(5, 1'b0, 2);
    set3(8'h10, 8'h01, 8'h48); send_pkt(4, 1'b0, 0);
    set3(8'h42, 8'h01, 8'h08); send_pkt(3, 1'b1, 1);
    set3(8'h42, 8'h01, 8'h40); send_pkt(3, 1'b0, 2);
    idle(16);
    compare("R10 burst", 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_target_off();
    t_command();
    t_reply();
    t_drop();
    t_promisc();
    t_ext();
    t_other();
    t_short();
    t_burst();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule